// File: doc/BRIEF.md
# PRP Scatter List Walker

This block turns one transfer request into an ordered stream of (address, length) segments for a DMA engine. A request carries a first pointer, a second pointer and a byte count. The first segment starts at the first pointer and runs to the end of its page or to the end of the transfer, whichever comes first. What remains after that is handled in one of two ways. If at most one page remains, the second pointer is the data address. If more remains, the second pointer addresses a list of 64-bit entries in host memory, and the walker fetches these entries one word at a time over a simple read port.

A full list page reserves its final slot for a link to the next list page. That slot is read as a link only while more than one page of data is still outstanding. Every pointer the walker relies on is validated. A bad pointer ends the walk with an invalid-field completion that also carries the do-not-retry flag. The page size is a power of two fixed by the `PAGE_SHIFT` parameter.

Top module: `sgl_prp_walker`

## Requirements
- R1: After reset the walker is idle. `req_ready` is 1, and `seg_valid`, `mrd_valid` and `cpl_valid` are 0.
- R2: A request whose first pointer is zero completes with `cpl_err`=1 and `cpl_dnr`=1. It emits no segment and issues no read. Every error completion sets both flags.
- R3: The first segment has address `req_prp1`. Its length is the smaller of `req_len` and the page size minus (`req_prp1` mod page size).
- R4: If the bytes left after the first segment are nonzero and no more than one page, one further segment is emitted at `req_prp2` with exactly that length, and no list read is issued. If `req_prp2` is not page aligned, an error completion follows the first segment instead.
- R5: If more than one page is left after the first segment, `req_prp2` is a list address, and entry k of a list page is read at list base + 8*k. Each returned 64-bit word is the entry value, least significant byte at the lowest address. Each data entry yields one segment at that address, with length equal to the smaller of one page and the bytes still left.
- R6: The entry in the last slot of a list page (slot page/8 - 1) is a link when more than one page is still left. The next read goes to slot 0 of the page it names, and no segment is emitted for it.
- R7: A list entry or link that is zero or not page aligned ends the walk with an error completion. No further read or segment follows it.
- R8: A zero `req_prp2` while bytes remain after the first segment gives an error completion.
- R9: The walker reads only the entries it needs: one per list-described page plus one per link, and nothing beyond the last needed entry.
- R10: While `seg_valid` (or `mrd_valid`) is 1 and its ready is 0, the valid and the address and length presented stay unchanged.
- R11: `seg_last` is 1 only on the segment that exhausts the transfer. A successful walk then gives a one-cycle `cpl_valid` with `cpl_err`=0, after which `req_ready` returns to 1. A zero-length request with a nonzero first pointer completes successfully with no segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request offered |
| req_ready | output | 1 | Walker idle, request taken when valid |
| req_prp1 | input | 64 | First data pointer, any byte offset |
| req_prp2 | input | 64 | Second pointer: data page or list address |
| req_len | input | LEN_W | Transfer length in bytes |
| seg_valid | output | 1 | Segment descriptor presented |
| seg_ready | input | 1 | DMA engine accepts the segment |
| seg_addr | output | 64 | Segment start address |
| seg_len | output | LEN_W | Segment length in bytes |
| seg_last | output | 1 | Segment ends the transfer |
| mrd_valid | output | 1 | List entry read request |
| mrd_ready | input | 1 | Read request accepted |
| mrd_addr | output | 64 | Byte address of the 64-bit entry |
| rsp_valid | input | 1 | Read data returned |
| rsp_data | input | 64 | Little-endian entry word |
| cpl_valid | output | 1 | One-cycle walk completion |
| cpl_err | output | 1 | Invalid-field error |
| cpl_dnr | output | 1 | Do-not-retry flag |

## Verification
The first segment is presented in the cycle after the request is taken. A read request appears one cycle after a list segment is accepted or after a link is taken. A segment built from an entry appears one cycle after that entry's response, and the completion appears one cycle after the final segment is accepted or after the failing pointer is seen. The bench drives and samples only on falling edges. It inserts random stalls on the segment and read handshakes and random response latency, and it records each event in the half-cycle in which the handshake is agreed. Because of this, every check compares recorded sequences (segments, read addresses, completion flags) against a reference walk computed from the same list memory, rather than expecting fixed cycle numbers.

// File: rtl/prp_walk_pkg.sv
package prp_walk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HEAD, ST_DIRECT, ST_LREQ, ST_LWAIT, ST_LSEG, ST_OK, ST_ERR
  } walk_st_t;

  typedef enum logic [1:0] {
    TAIL_NONE, TAIL_DIRECT, TAIL_LIST, TAIL_FAIL
  } tail_kind_t;

  function automatic logic [63:0] page_mask(input int unsigned sh);
    return (64'd1 << sh) - 64'd1;
  endfunction

  // bytes from addr up to the next page boundary
  function automatic logic [63:0] page_room(input logic [63:0] a, input int unsigned sh);
    return (64'd1 << sh) - (a & page_mask(sh));
  endfunction

  // nonzero and page aligned
  function automatic logic page_ok(input logic [63:0] a, input int unsigned sh);
    return (a != 64'd0) && ((a & page_mask(sh)) == 64'd0);
  endfunction

  function automatic logic [63:0] min_u64(input logic [63:0] a, input logic [63:0] b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/prp_head_split.sv
module prp_head_split
  import prp_walk_pkg::*;
#(
  parameter int LEN_W      = 32,
  parameter int PAGE_SHIFT = 12
) (
  input  logic [63:0]      prp1,
  input  logic [63:0]      prp2,
  input  logic [LEN_W-1:0] len,
  output logic [LEN_W-1:0] head_len,
  output logic [LEN_W-1:0] tail_len,
  output tail_kind_t       tail_kind,
  output logic             prp1_zero,
  output logic             len_zero
);
  localparam logic [63:0] PSZ64 = 64'd1 << PAGE_SHIFT;

  logic [63:0] len64, head64, tail64;

  always_comb begin
    len64  = 64'(len);
    head64 = min_u64(len64, page_room(prp1, PAGE_SHIFT));
    tail64 = len64 - head64;
    head_len = head64[LEN_W-1:0];
    tail_len = tail64[LEN_W-1:0];
    prp1_zero = (prp1 == 64'd0);
    len_zero  = (len == '0);
    if (tail64 == 64'd0)           tail_kind = TAIL_NONE;
    else if (prp2 == 64'd0)        tail_kind = TAIL_FAIL;
    else if (tail64 <= PSZ64)      tail_kind = page_ok(prp2, PAGE_SHIFT) ? TAIL_DIRECT : TAIL_FAIL;
    else                           tail_kind = TAIL_LIST;
  end
endmodule

// File: rtl/prp_entry_eval.sv
module prp_entry_eval
  import prp_walk_pkg::*;
#(
  parameter int LEN_W      = 32,
  parameter int PAGE_SHIFT = 12,
  localparam int IDX_W     = PAGE_SHIFT - 3
) (
  input  logic [63:0]      entry,
  input  logic [LEN_W-1:0] rem,
  input  logic [IDX_W-1:0] slot,
  output logic             is_link,
  output logic             is_bad,
  output logic [LEN_W-1:0] piece_len
);
  localparam logic [63:0] PSZ64 = 64'd1 << PAGE_SHIFT;

  logic [63:0] rem64, piece64;

  always_comb begin
    rem64     = 64'(rem);
    piece64   = min_u64(rem64, PSZ64);
    piece_len = piece64[LEN_W-1:0];
    is_link   = (slot == '1) && (rem64 > PSZ64);
    is_bad    = !page_ok(entry, PAGE_SHIFT);
  end
endmodule

// File: rtl/sgl_prp_walker.sv
module sgl_prp_walker
  import prp_walk_pkg::*;
#(
  parameter int LEN_W      = 32,
  parameter int PAGE_SHIFT = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [63:0]      req_prp1,
  input  logic [63:0]      req_prp2,
  input  logic [LEN_W-1:0] req_len,
  output logic             seg_valid,
  input  logic             seg_ready,
  output logic [63:0]      seg_addr,
  output logic [LEN_W-1:0] seg_len,
  output logic             seg_last,
  output logic             mrd_valid,
  input  logic             mrd_ready,
  output logic [63:0]      mrd_addr,
  input  logic             rsp_valid,
  input  logic [63:0]      rsp_data,
  output logic             cpl_valid,
  output logic             cpl_err,
  output logic             cpl_dnr
);
  localparam int          IDX_W = PAGE_SHIFT - 3;
  localparam logic [63:0] PSZ64 = 64'd1 << PAGE_SHIFT;

  walk_st_t         st;
  tail_kind_t       tail_q;
  logic [63:0]      prp2_q, addr_q, list_q;
  logic [LEN_W-1:0] len_q, rem_q;
  logic [IDX_W-1:0] slot_q;

  logic [LEN_W-1:0] hd_len, tl_len, ent_len;
  tail_kind_t       tl_kind;
  logic             p1_zero, l_zero, ent_link, ent_bad;

  prp_head_split #(.LEN_W(LEN_W), .PAGE_SHIFT(PAGE_SHIFT)) u_head (
    .prp1(req_prp1), .prp2(req_prp2), .len(req_len),
    .head_len(hd_len), .tail_len(tl_len), .tail_kind(tl_kind),
    .prp1_zero(p1_zero), .len_zero(l_zero)
  );

  prp_entry_eval #(.LEN_W(LEN_W), .PAGE_SHIFT(PAGE_SHIFT)) u_entry (
    .entry(rsp_data), .rem(rem_q), .slot(slot_q),
    .is_link(ent_link), .is_bad(ent_bad), .piece_len(ent_len)
  );

  // named internal events
  logic seg_fire, rd_fire, link_taken, walk_abort, list_seg;
  assign seg_fire   = seg_valid && seg_ready;
  assign rd_fire    = mrd_valid && mrd_ready;
  assign link_taken = (st == ST_LWAIT) && rsp_valid && !ent_bad && ent_link;
  assign walk_abort = (st == ST_LWAIT) && rsp_valid && ent_bad;
  assign list_seg   = (st == ST_LSEG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      tail_q <= TAIL_NONE;
      prp2_q <= '0;
      addr_q <= '0;
      list_q <= '0;
      len_q  <= '0;
      rem_q  <= '0;
      slot_q <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (req_valid) begin
          prp2_q <= req_prp2;
          addr_q <= req_prp1;
          len_q  <= hd_len;
          rem_q  <= tl_len;
          tail_q <= tl_kind;
          if (p1_zero)     st <= ST_ERR;
          else if (l_zero) st <= ST_OK;
          else             st <= ST_HEAD;
        end
        ST_HEAD: if (seg_ready) begin
          unique case (tail_q)
            TAIL_NONE:   st <= ST_OK;
            TAIL_DIRECT: begin
              addr_q <= prp2_q;
              len_q  <= rem_q;
              st     <= ST_DIRECT;
            end
            TAIL_LIST: begin
              list_q <= prp2_q;
              slot_q <= '0;
              st     <= ST_LREQ;
            end
            default:     st <= ST_ERR;
          endcase
        end
        ST_DIRECT: if (seg_ready) st <= ST_OK;
        ST_LREQ:   if (mrd_ready) st <= ST_LWAIT;
        ST_LWAIT: if (rsp_valid) begin
          if (ent_bad) st <= ST_ERR;
          else if (ent_link) begin
            list_q <= rsp_data;
            slot_q <= '0;
            st     <= ST_LREQ;
          end else begin
            addr_q <= rsp_data;
            len_q  <= ent_len;
            st     <= ST_LSEG;
          end
        end
        ST_LSEG: if (seg_ready) begin
          rem_q  <= rem_q - len_q;
          slot_q <= slot_q + IDX_W'(1);
          st     <= (rem_q == len_q) ? ST_OK : ST_LREQ;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready = (st == ST_IDLE);
    seg_valid = (st == ST_HEAD) || (st == ST_DIRECT) || (st == ST_LSEG);
    seg_addr  = addr_q;
    seg_len   = len_q;
    seg_last  = ((st == ST_HEAD) && (tail_q == TAIL_NONE)) || (st == ST_DIRECT) ||
                ((st == ST_LSEG) && (rem_q == len_q));
    mrd_valid = (st == ST_LREQ);
    mrd_addr  = list_q + (64'(slot_q) << 3);
    cpl_valid = (st == ST_OK) || (st == ST_ERR);
    cpl_err   = (st == ST_ERR);
    cpl_dnr   = (st == ST_ERR);
  end

  // R10
  seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid && !seg_ready |=> seg_valid && $stable(seg_addr) && $stable(seg_len));
  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mrd_valid && !mrd_ready |=> mrd_valid && $stable(mrd_addr));
  // R3
  seg_len_rng_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> (seg_len != '0) && (64'(seg_len) <= PSZ64));
  // R7
  list_seg_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    list_seg |-> page_ok(seg_addr, PAGE_SHIFT));
  // R6
  link_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_taken |=> mrd_valid && (mrd_addr == $past(rsp_data)));
  // R7
  abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_abort |=> cpl_valid && cpl_err && !mrd_valid && !seg_valid);
  // R11
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({seg_valid, mrd_valid, cpl_valid}));
  // R11
  back_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |=> req_ready && !cpl_valid);
  // R9
  rd_only_after_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> !mrd_valid);
  // R11
  last_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_fire && seg_last |=> cpl_valid && !cpl_err);
endmodule

// File: tb/test_sgl_prp_walker.sv
module test_sgl_prp_walker;
  localparam int          CLK_PERIOD = 10;
  localparam int          PSH    = 6;
  localparam int          PSZ    = 64;
  localparam int          EPP    = PSZ / 8;
  localparam int          LW     = 32;
  localparam logic [63:0] LBASE  = 64'h8000;
  localparam int          LWORDS = 256;
  localparam int          MAXN   = 128;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, seg_ready = 1'b0, mrd_ready = 1'b0, rsp_valid = 1'b0;
  logic [63:0] req_prp1 = '0, req_prp2 = '0, rsp_data = '0;
  logic [LW-1:0] req_len = '0;
  logic req_ready, seg_valid, seg_last, mrd_valid, cpl_valid, cpl_err, cpl_dnr;
  logic [63:0] seg_addr, mrd_addr;
  logic [LW-1:0] seg_len;

  always #(CLK_PERIOD/2) clk = ~clk;

  sgl_prp_walker #(.LEN_W(LW), .PAGE_SHIFT(PSH)) i_sgl_prp_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_prp1(req_prp1), .req_prp2(req_prp2), .req_len(req_len),
    .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr),
    .seg_len(seg_len), .seg_last(seg_last), .mrd_valid(mrd_valid),
    .mrd_ready(mrd_ready), .mrd_addr(mrd_addr), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .cpl_valid(cpl_valid), .cpl_err(cpl_err), .cpl_dnr(cpl_dnr)
  );

  int total = 0, bad = 0;
  logic [63:0] lm [LWORDS];

  logic [63:0] ex_a [MAXN]; int ex_l [MAXN]; logic ex_last [MAXN]; int ex_n;
  logic [63:0] ex_ra [MAXN]; int ex_rn; logic ex_err;
  logic [63:0] ob_a [MAXN]; int ob_l [MAXN]; logic ob_last [MAXN]; int ob_n;
  logic [63:0] ob_ra [MAXN]; int ob_rn; logic ob_err, ob_dnr, ob_done;

  task automatic chk(input logic ok, input string tag, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mem_rd(input logic [63:0] a);
    logic [63:0] w;
    w = (a - LBASE) >> 3;
    if (a >= LBASE && w < LWORDS) return lm[w[7:0]];
    return 64'd0;
  endfunction

  function automatic logic good_ptr(input logic [63:0] a);
    return a != 0 && a[PSH-1:0] == '0;
  endfunction

  task automatic push(input logic [63:0] a, input int l, input logic last);
    ex_a[ex_n] = a; ex_l[ex_n] = l; ex_last[ex_n] = last; ex_n++;
  endtask

  // reference walk written from the requirements
  task automatic model(input logic [63:0] p1, input logic [63:0] p2, input int len);
    int off, first, rem, slot, piece;
    logic [63:0] base, e;
    ex_n = 0; ex_rn = 0; ex_err = 0;
    if (p1 == 0) begin ex_err = 1; return; end
    if (len == 0) return;
    off = int'(p1[PSH-1:0]);
    first = (len < PSZ - off) ? len : PSZ - off;
    rem = len - first;
    push(p1, first, rem == 0);
    if (rem == 0) return;
    if (p2 == 0) begin ex_err = 1; return; end
    if (rem <= PSZ) begin
      if (p2[PSH-1:0] != 0) begin ex_err = 1; return; end
      push(p2, rem, 1'b1); return;
    end
    base = p2; slot = 0;
    while (rem > 0) begin
      ex_ra[ex_rn] = base + 64'(slot * 8); ex_rn++;
      e = mem_rd(base + 64'(slot * 8));
      if (!good_ptr(e)) begin ex_err = 1; return; end
      if (slot == EPP - 1 && rem > PSZ) begin base = e; slot = 0; end
      else begin
        piece = rem < PSZ ? rem : PSZ;
        rem -= piece;
        push(e, piece, rem == 0);
        slot++;
      end
    end
  endtask

  task automatic run(input logic [63:0] p1, input logic [63:0] p2, input int len,
                     input string tag);
    logic pend = 0; int cnt = 0; logic [63:0] paddr = 0;
    logic held = 0; logic [63:0] haddr = 0; int cyc = 0;
    model(p1, p2, len);
    ob_n = 0; ob_rn = 0; ob_done = 0; ob_err = 0; ob_dnr = 0;
    @(negedge clk);
    chk(req_ready, tag, "req_ready before request", req_ready, 1);
    req_valid = 1; req_prp1 = p1; req_prp2 = p2; req_len = LW'(len);
    while (!ob_done) begin
      @(negedge clk);
      req_valid = 0;
      cyc++;
      if (cyc > 3000) begin
        chk(1'b0, tag, "watchdog expired", cyc, 0);
        break;
      end
      if (cpl_valid) begin ob_done = 1; ob_err = cpl_err; ob_dnr = cpl_dnr; end
      // R10 stalled segment holds
      if (held) chk(seg_valid && seg_addr == haddr, "R10", "stalled segment held",
                    seg_addr, haddr);
      held = 0; seg_ready = 0;
      if (seg_valid) begin
        seg_ready = ($urandom % 4) != 0;
        if (seg_ready) begin
          if (ob_n < MAXN) begin
            ob_a[ob_n] = seg_addr; ob_l[ob_n] = int'(seg_len); ob_last[ob_n] = seg_last;
          end
          ob_n++;
        end else begin held = 1; haddr = seg_addr; end
      end
      rsp_valid = 0; mrd_ready = 0;
      if (pend) begin
        if (cnt == 0) begin rsp_valid = 1; rsp_data = mem_rd(paddr); pend = 0; end
        else cnt--;
      end else if (mrd_valid) begin
        mrd_ready = ($urandom % 3) != 0;
        if (mrd_ready) begin
          if (ob_rn < MAXN) ob_ra[ob_rn] = mrd_addr;
          ob_rn++; pend = 1; cnt = $urandom % 3; paddr = mrd_addr;
        end
      end
    end
    seg_ready = 0; mrd_ready = 0; rsp_valid = 0;
    chk(ob_err == ex_err, tag, "completion error flag", ob_err, ex_err);
    chk(ob_dnr == ex_err, "R2", "do-not-retry flag", ob_dnr, ex_err);
    chk(ob_n == ex_n, tag, "segment count", ob_n, ex_n);
    chk(ob_rn == ex_rn, "R9", "list read count", ob_rn, ex_rn);
    for (int i = 0; i < ex_n && i < ob_n; i++) begin
      chk(ob_a[i] == ex_a[i], tag, $sformatf("seg %0d addr", i), ob_a[i], ex_a[i]);
      chk(ob_l[i] == ex_l[i], tag, $sformatf("seg %0d len", i), ob_l[i], ex_l[i]);
      chk(ob_last[i] == ex_last[i], "R11", $sformatf("seg %0d last", i),
          ob_last[i], ex_last[i]);
    end
    for (int i = 0; i < ex_rn && i < ob_rn; i++)
      chk(ob_ra[i] == ex_ra[i], "R5", $sformatf("read %0d addr", i), ob_ra[i], ex_ra[i]);
  endtask

  task automatic fill_lists();
    for (int w = 0; w < LWORDS; w++) begin
      if (w % EPP == EPP - 1) lm[w] = LBASE + 64'((w / EPP + 1) * PSZ);
      else lm[w] = (64'($urandom) + 64'd1) << PSH;
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    fill_lists();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready == 1, "R1", "req_ready in reset", req_ready, 1);
    chk(!seg_valid && !mrd_valid && !cpl_valid, "R1", "no valid in reset",
        {seg_valid, mrd_valid, cpl_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1, "R1", "req_ready after reset", req_ready, 1);

    run(64'd0, LBASE, 200, "R2");                     // zero first pointer
    run(64'h1_0010, 64'd0, 48, "R3");                 // fits in first page
    run(64'h1_0000, 64'd0, 0, "R11");                 // zero length
    run(64'h2_003c, 64'h5_0000, 4 + 64, "R4");        // direct second page
    run(64'h2_003c, 64'h5_0008, 4 + 64, "R4");        // misaligned direct
    run(64'h2_0000, 64'd0, 100, "R8");                // missing second pointer
    run(64'h3_0000, LBASE, 64 * 12, "R6");            // link followed
    run(64'h3_0000, LBASE, 64 * 9, "R9");             // last slot is data
    lm[2] = 64'd0;
    run(64'h3_0000, LBASE, 64 * 6, "R7");             // zero entry
    fill_lists();
    lm[EPP - 1] = LBASE + 64'd8 + 64'(PSZ);
    run(64'h3_0000, LBASE, 64 * 14, "R7");            // misaligned link
    fill_lists();

    for (int t = 0; t < 40; t++) begin
      int np, off, len;
      logic [63:0] p1, p2;
      fill_lists();
      if ($urandom % 8 == 0) begin
        int w = $urandom % 24;
        lm[w] = ($urandom % 2) ? 64'd0 : lm[w] + 64'd8;
      end
      np  = 1 + $urandom % 20;
      off = ($urandom % 2) ? int'($urandom % PSZ) : 0;
      len = np * PSZ - off - int'($urandom % PSZ);
      if (len < 1) len = 1;
      p1  = (64'($urandom) << PSH) | 64'(off);
      if (p1 == 0) p1 = 64'h40;
      p2  = LBASE + 64'(($urandom % 4) * PSZ);
      run(p1, p2, len, "R5");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule